// File: doc/BRIEF.md
# Programmable Interrupt Countdown Timer

This block is a local countdown timer that issues interrupt requests to an interrupt core. Software sets a timer entry (vector, delivery-mode field, mask and a one-shot/periodic select), a divide code and an initial count through a small register port. The count runs on bus ticks, marked by a clock enable, after they pass through a power-of-two prescaler. When the count expires the block raises a one-cycle request that carries the 8-bit vector and the 3-bit delivery-mode field. The interrupt core acts on the mode field. This block only reports it.

In one-shot mode the count runs down from the initial value, stops at zero and requests once. In periodic mode the count reloads after it has sat at zero for one tick, so the period is the initial count plus one prescaled ticks, and a request goes out at every reload. A write of the initial count restarts both the count and the prescaler.

Register map (2-bit address): 0 = timer entry, 1 = initial count, 2 = current count (read only), 3 = divide configuration.

Top module: `ictmr_top`

## Requirements
- R1: After reset the timer entry reads 0x00010000 (only the mask bit is set). The initial count, the current count and the divide configuration read 0, and irq_req is low.
- R2: A divide-configuration write keeps only bits 3, 1 and 0 of the data. Reads return those bits in place and 0 elsewhere. The code {bit3,bit1,bit0} selects a prescale shift of (code+1) mod 8, so code 7 counts on every bus tick and code 0 counts on every second bus tick.
- R3: The prescaler counts cycles with tick_en high. A prescaled tick occurs on the tick_en cycle that completes each group of 2^shift enables. A write of the initial count clears the prescaler.
- R4: In one-shot mode (entry bit 17 = 0) each prescaled tick lowers a nonzero current count by one. The count holds at zero. Exactly one request is made, on the tick that brings the count to zero. An initial count of zero makes no request.
- R5: In periodic mode (entry bit 17 = 1), a prescaled tick that finds the count at zero reloads it with the initial count and makes a request. Requests therefore recur every initial-count-plus-one prescaled ticks.
- R6: In periodic mode an initial count of zero makes no request.
- R7: A write of the initial count loads that value into the current count on the same clock edge, and counting restarts from the write.
- R8: While entry bit 16 (mask) is set, an expiry makes no request. Clearing the mask after a one-shot expiry does not revive that expiry.
- R9: irq_req is registered. It is high for exactly one cycle, starting on the clock edge of the expiring tick. irq_vector carries entry bits 7:0 and irq_mode carries entry bits 10:8 as they stood at that tick.
- R10: Writes to the current-count address are ignored. Reading any register changes no state.
- R11: The timer entry keeps bits 17, 16, 10:8 and 7:0 of a write. All other bits read as 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| tick_en | input | 1 | Bus tick enable, one cycle per tick |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | 2 | Register address (0 entry, 1 initial, 2 current, 3 divide) |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data for reg_addr, combinational |
| irq_req | output | 1 | One-cycle interrupt request |
| irq_vector | output | 8 | Vector of the request, valid with irq_req |
| irq_mode | output | 3 | Delivery-mode field of the request, valid with irq_req |

## Verification
A register write is visible on reg_rdata straight after the clock edge that takes it. A prescaled tick that expires the count shows irq_req, irq_vector and irq_mode straight after that same edge, so every result is due one edge after its stimulus. The bench drives each stimulus, waits for the edge, steps a behavioural reference model and then compares the request and the read data a short time after the edge. The directed checks count the exact step of each request: the fifth tick for a one-shot of 5, a request every eight steps for a periodic count of 3 at divide-by-2, and the 23rd step when tick_en is high only on every other cycle at divide-by-4.

// File: rtl/ictmr_pkg.sv
// Shared definitions for the interrupt countdown timer.
// Assumes a 32-bit register port and a 2-bit register address.
package ictmr_pkg;
    localparam int DATA_W     = 32;
    localparam int SHIFT_W    = 3;
    localparam int VEC_W      = 8;
    localparam int MODE_W     = 3;
    localparam int MODE_LSB   = 8;
    localparam int MASK_BIT   = 16;
    localparam int PERIOD_BIT = 17;

    typedef enum logic [1:0] {
        ADDR_ENTRY = 2'd0,
        ADDR_INIT  = 2'd1,
        ADDR_CUR   = 2'd2,
        ADDR_DIV   = 2'd3
    } reg_addr_e;

    typedef struct packed {
        logic              periodic;
        logic              masked;
        logic [MODE_W-1:0] mode;
        logic [VEC_W-1:0]  vector;
    } entry_t;

    // Turn the kept divide bits into a prescale shift: (code + 1) mod 8.
    function automatic logic [SHIFT_W-1:0] div_to_shift(input logic [3:0] d);
        return {d[3], d[1], d[0]} + 3'd1;
    endfunction
endpackage

// File: rtl/ictmr_regs.sv
// Register file of the countdown timer: timer entry, initial count and
// divide configuration, plus the read multiplexer.
// Assumes one write per cycle. The current count comes from the counter.
module ictmr_regs
    import ictmr_pkg::*;
#(
    parameter int CNT_W = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              reg_we,
    input  logic [1:0]        reg_addr,
    input  logic [DATA_W-1:0] reg_wdata,
    input  logic [CNT_W-1:0]  cur_cnt,
    output logic [DATA_W-1:0] reg_rdata,
    output entry_t            entry_q,
    output logic [CNT_W-1:0]  init_q,
    output logic [3:0]        div_q,
    output logic [SHIFT_W-1:0] shift,
    output logic              init_load
);
    reg_addr_e addr;
    assign addr      = reg_addr_e'(reg_addr);
    assign init_load = reg_we && (addr == ADDR_INIT);
    assign shift     = div_to_shift(div_q);

    // Store register writes. The current-count address takes no write.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            entry_q <= '{periodic: 1'b0, masked: 1'b1, mode: '0, vector: '0};
            init_q  <= '0;
            div_q   <= '0;
        end else if (reg_we) begin
            case (addr)
                ADDR_ENTRY: entry_q <= '{periodic: reg_wdata[PERIOD_BIT],
                                         masked:   reg_wdata[MASK_BIT],
                                         mode:     reg_wdata[MODE_LSB +: MODE_W],
                                         vector:   reg_wdata[VEC_W-1:0]};
                ADDR_INIT:  init_q  <= reg_wdata[CNT_W-1:0];
                ADDR_DIV:   div_q   <= {reg_wdata[3], 1'b0, reg_wdata[1:0]};
                default:    ;
            endcase
        end
    end

    // Select read data for the addressed register.
    always_comb begin
        reg_rdata = '0;
        case (addr)
            ADDR_ENTRY: begin
                reg_rdata[PERIOD_BIT]            = entry_q.periodic;
                reg_rdata[MASK_BIT]              = entry_q.masked;
                reg_rdata[MODE_LSB +: MODE_W]    = entry_q.mode;
                reg_rdata[VEC_W-1:0]             = entry_q.vector;
            end
            ADDR_INIT: reg_rdata = DATA_W'(init_q);
            ADDR_CUR:  reg_rdata = DATA_W'(cur_cnt);
            default:   reg_rdata = DATA_W'(div_q);
        endcase
    end
endmodule

// File: rtl/ictmr_prescaler.sv
// Free-running bus-tick prescaler. It issues one prescaled tick each time
// its low `shift` bits wrap. Cleared by a write of the initial count.
// Assumes shift never exceeds 2**SHIFT_W - 1.
module ictmr_prescaler
    import ictmr_pkg::*;
#(
    parameter int SW = SHIFT_W
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          tick_en,
    input  logic          clear,
    input  logic [SW-1:0] shift,
    output logic          ptick
);
    localparam int PSC_W = (1 << SW) - 1;

    logic [PSC_W-1:0] psc;
    logic [PSC_W-1:0] lane_ok;

    // Count bus ticks, restart on clear.
    always_ff @(posedge clk) begin
        if (!rst_n || clear) psc <= '0;
        else if (tick_en)    psc <= psc + 1'b1;
    end

    // A bit below the shift must be one. Bits at or above it do not matter.
    for (genvar g = 0; g < PSC_W; g++) begin : g_lane
        assign lane_ok[g] = psc[g] | (g >= int'(shift));
    end

    assign ptick = tick_en & (&lane_ok);
endmodule

// File: rtl/ictmr_counter.sv
// Current-count register and expiry logic for one-shot and periodic modes.
// Issues a registered one-cycle request with vector and mode captured.
// Assumes entry and initial count are the registered values from the file.
module ictmr_counter
    import ictmr_pkg::*;
#(
    parameter int CNT_W = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              ptick,
    input  logic              load,
    input  logic [CNT_W-1:0]  load_val,
    input  logic [CNT_W-1:0]  init_q,
    input  entry_t            entry_q,
    output logic [CNT_W-1:0]  cur_cnt,
    output logic              irq_req,
    output logic [VEC_W-1:0]  irq_vector,
    output logic [MODE_W-1:0] irq_mode
);
    logic expire;

    // Decide whether this prescaled tick is an expiry event.
    always_comb begin
        if (entry_q.periodic) expire = ptick && (cur_cnt == '0) && (init_q != '0);
        else                  expire = ptick && (cur_cnt == CNT_W'(1));
    end

    // Step the count: load, reload on periodic wrap, or run down to zero.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cur_cnt <= '0;
        end else if (load) begin
            cur_cnt <= load_val;
        end else if (ptick) begin
            if (cur_cnt != '0)         cur_cnt <= cur_cnt - 1'b1;
            else if (entry_q.periodic) cur_cnt <= init_q;
        end
    end

    // Register the request and capture its vector and mode.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            irq_req    <= 1'b0;
            irq_vector <= '0;
            irq_mode   <= '0;
        end else begin
            irq_req <= expire && !load && !entry_q.masked;
            if (expire && !load && !entry_q.masked) begin
                irq_vector <= entry_q.vector;
                irq_mode   <= entry_q.mode;
            end
        end
    end
endmodule

// File: rtl/ictmr_top.sv
// Top of the interrupt countdown timer: registers, prescaler and counter.
// Assumes tick_en marks bus ticks and the interrupt core takes irq_req
// as a one-cycle event.
module ictmr_top
    import ictmr_pkg::*;
#(
    parameter int CNT_W = 32
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        tick_en,
    input  logic        reg_we,
    input  logic [1:0]  reg_addr,
    input  logic [31:0] reg_wdata,
    output logic [31:0] reg_rdata,
    output logic        irq_req,
    output logic [7:0]  irq_vector,
    output logic [2:0]  irq_mode
);
    entry_t             entry_q;
    logic [CNT_W-1:0]   init_q;
    logic [CNT_W-1:0]   cur_cnt;
    logic [3:0]         div_q;
    logic [SHIFT_W-1:0] shift;
    logic               init_load;
    logic               ptick;

    ictmr_regs #(.CNT_W(CNT_W)) u_regs (
        .clk(clk), .rst_n(rst_n), .reg_we(reg_we), .reg_addr(reg_addr),
        .reg_wdata(reg_wdata), .cur_cnt(cur_cnt), .reg_rdata(reg_rdata),
        .entry_q(entry_q), .init_q(init_q), .div_q(div_q), .shift(shift),
        .init_load(init_load)
    );

    ictmr_prescaler #(.SW(SHIFT_W)) u_psc (
        .clk(clk), .rst_n(rst_n), .tick_en(tick_en), .clear(init_load),
        .shift(shift), .ptick(ptick)
    );

    ictmr_counter #(.CNT_W(CNT_W)) u_cnt (
        .clk(clk), .rst_n(rst_n), .ptick(ptick), .load(init_load),
        .load_val(reg_wdata[CNT_W-1:0]), .init_q(init_q), .entry_q(entry_q),
        .cur_cnt(cur_cnt), .irq_req(irq_req), .irq_vector(irq_vector),
        .irq_mode(irq_mode)
    );
endmodule

// File: rtl/ictmr_checker.sv
// Property checker for the countdown timer, bound into ictmr_top.
// Assumes the default 32-bit count width.
module ictmr_checker (
    input logic        clk,
    input logic        rst_n,
    input logic        reg_we,
    input logic [1:0]  reg_addr,
    input logic [31:0] reg_wdata,
    input logic        irq_req,
    input logic        ptick,
    input logic        masked,
    input logic        periodic,
    input logic [3:0]  div_q,
    input logic [31:0] cur_cnt,
    input logic [17:0] entry_bits
);
    logic init_wr;
    assign init_wr = reg_we && (reg_addr == 2'd1);

    a_r1_reset_entry: assert property (@(posedge clk)
        !rst_n |=> (entry_bits == 18'h10000 && cur_cnt == 32'd0 && !irq_req));

    a_r2_div_kept_bits: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_we && reg_addr == 2'd3) |=> (div_q == ($past(reg_wdata[3:0]) & 4'hB)));

    a_r3_req_needs_tick: assert property (@(posedge clk) disable iff (!rst_n)
        irq_req |-> $past(ptick));

    a_r4_oneshot_never_rises: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(!periodic) && $past(!init_wr)) |-> (cur_cnt <= $past(cur_cnt)));

    a_r7_restart_load: assert property (@(posedge clk) disable iff (!rst_n)
        init_wr |=> (cur_cnt == $past(reg_wdata)));

    a_r8_mask_blocks: assert property (@(posedge clk) disable iff (!rst_n)
        irq_req |-> $past(!masked));

    a_r9_single_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        irq_req |=> !irq_req);
endmodule

bind ictmr_top ictmr_checker u_chk (
    .clk(clk), .rst_n(rst_n), .reg_we(reg_we), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .irq_req(irq_req), .ptick(ptick),
    .masked(entry_q.masked), .periodic(entry_q.periodic), .div_q(div_q),
    .cur_cnt(cur_cnt), .entry_bits({entry_q.periodic, entry_q.masked, 5'd0,
                                    entry_q.mode, entry_q.vector})
);

// File: tb/tb_ictmr_top.sv
// Self-checking bench: behavioural reference model stepped on every clock,
// plus directed checks on request timing.
module tb_ictmr_top;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        tick_en = 1'b0;
    logic        reg_we = 1'b0;
    logic [1:0]  reg_addr = 2'd0;
    logic [31:0] reg_wdata = 32'd0;
    logic [31:0] reg_rdata;
    logic        irq_req;
    logic [7:0]  irq_vector;
    logic [2:0]  irq_mode;

    int checks = 0;
    int errors = 0;
    bit done = 0;

    // Reference model state
    bit          m_per, m_mask, m_fire;
    int unsigned m_mode, m_vec, m_init, m_cur, m_div, m_psc, m_fvec, m_fmode;

    always #4 clk = ~clk;

    ictmr_top dut (
        .clk(clk), .rst_n(rst_n), .tick_en(tick_en), .reg_we(reg_we),
        .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
        .irq_req(irq_req), .irq_vector(irq_vector), .irq_mode(irq_mode)
    );

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    function automatic int unsigned m_read(input int a);
        case (a)
            0: return (32'(m_per) << 17) | (32'(m_mask) << 16) | (m_mode << 8) | m_vec;
            1: return m_init;
            2: return m_cur;
            default: return m_div;
        endcase
    endfunction

    // Model update on one clock edge with the inputs held in that cycle.
    task automatic m_edge();
        int unsigned sh, lim;
        bit tk;
        if (!rst_n) begin
            m_per = 0; m_mask = 1; m_mode = 0; m_vec = 0; m_init = 0;
            m_cur = 0; m_div = 0; m_psc = 0; m_fire = 0; m_fvec = 0; m_fmode = 0;
            return;
        end
        sh  = (((m_div >> 3) & 1) * 4 + (m_div & 3) + 1) % 8;
        lim = (1 << sh) - 1;
        tk  = tick_en && ((m_psc & lim) == lim);
        m_fire = 0;
        if (reg_we && reg_addr == 2'd1) begin
            m_cur = reg_wdata; m_psc = 0;
        end else begin
            if (tick_en) m_psc = (m_psc + 1) % 128;
            if (tk) begin
                if (m_cur != 0) begin
                    m_cur = m_cur - 1;
                    if (!m_per && m_cur == 0 && !m_mask) m_fire = 1;
                end else if (m_per) begin
                    m_cur = m_init;
                    if (m_init != 0 && !m_mask) m_fire = 1;
                end
            end
        end
        if (m_fire) begin m_fvec = m_vec; m_fmode = m_mode; end
        if (reg_we) begin
            case (reg_addr)
                2'd0: begin
                    m_per = reg_wdata[17]; m_mask = reg_wdata[16];
                    m_mode = 32'(reg_wdata[10:8]); m_vec = 32'(reg_wdata[7:0]);
                end
                2'd1: m_init = reg_wdata;
                2'd3: m_div = reg_wdata & 32'hB;
                default: ;
            endcase
        end
    endtask

    // One clock: drive, edge, model, compare shortly after the edge.
    task automatic step(input bit we, input logic [1:0] a, input logic [31:0] wd, input bit te);
        reg_we = we; reg_addr = a; reg_wdata = wd; tick_en = te;
        @(posedge clk);
        m_edge();
        #2;
        chk("R9 model irq_req", {31'd0, irq_req}, {31'd0, m_fire});
        if (m_fire) begin
            chk("R9 model vector", {24'd0, irq_vector}, m_fvec);
            chk("R9 model mode", {29'd0, irq_mode}, m_fmode);
        end
        chk("R10 model rdata", reg_rdata, m_read(int'(a)));
    endtask

    task automatic wr(input logic [1:0] a, input logic [31:0] wd);
        step(1, a, wd, 0);
    endtask

    // Run n idle steps reading the current count; report request steps.
    task automatic run(input int n, input bit alt, output int cnt, output int first, output int last);
        cnt = 0; first = 0; last = 0;
        for (int i = 1; i <= n; i++) begin
            step(0, 2'd2, 32'd0, alt ? (i % 2 == 1) : 1'b1);
            if (irq_req) begin
                cnt++;
                if (first == 0) first = i;
                last = i;
            end
        end
    endtask

    // Watchdog: a hung run counts as a failure.
    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            errors++;
            $display("FAIL watchdog expired");
            $display("  CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        int cnt, first, last;
        logic [31:0] lfsr;
        // Reset
        for (int i = 0; i < 3; i++) step(0, 2'd0, 32'd0, 0);
        rst_n = 1'b1;
        step(0, 2'd0, 0, 0); chk("R1 entry reset", reg_rdata, 32'h0001_0000);
        chk("R1 irq low", {31'd0, irq_req}, 32'd0);
        step(0, 2'd1, 0, 0); chk("R1 init reset", reg_rdata, 32'd0);
        step(0, 2'd2, 0, 0); chk("R1 cur reset", reg_rdata, 32'd0);
        step(0, 2'd3, 0, 0); chk("R1 div reset", reg_rdata, 32'd0);

        // R11 entry field masking
        wr(2'd0, 32'hFFFF_FFFF); chk("R11 entry kept bits", reg_rdata, 32'h0003_07FF);
        // R2 divide masking, code 7 -> every tick
        wr(2'd3, 32'hFFFF_FFFF); chk("R2 div kept bits", reg_rdata, 32'h0000_000B);

        // R4 one-shot count 5
        wr(2'd0, 32'h0000_0241);
        wr(2'd1, 32'd5);
        run(20, 0, cnt, first, last);
        chk("R4 oneshot first step", first, 32'd5);
        chk("R4 oneshot single", cnt, 32'd1);
        chk("R4 oneshot holds zero", reg_rdata, 32'd0);
        // R4 one-shot zero count
        wr(2'd1, 32'd0);
        run(10, 0, cnt, first, last);
        chk("R4 zero count no request", cnt, 32'd0);

        // R5 periodic count 3, divide code 0 (by 2)
        wr(2'd3, 32'd0);
        wr(2'd0, 32'h0002_0377);
        wr(2'd1, 32'd3);
        run(40, 0, cnt, first, last);
        chk("R5 periodic first", first, 32'd8);
        chk("R5 periodic count", cnt, 32'd5);
        chk("R5 periodic last", last, 32'd40);

        // R3 divide code 1 (by 4), tick_en every other cycle, count 2
        wr(2'd3, 32'd1);
        wr(2'd1, 32'd2);
        run(24, 1, cnt, first, last);
        chk("R3 prescaled first", first, 32'd23);

        // R6 periodic zero count
        wr(2'd1, 32'd0);
        run(40, 0, cnt, first, last);
        chk("R6 periodic zero no request", cnt, 32'd0);

        // R7 restart mid count
        wr(2'd3, 32'hB);
        wr(2'd0, 32'h0000_0010);
        wr(2'd1, 32'd10);
        run(6, 0, cnt, first, last);
        wr(2'd1, 32'd4);
        step(0, 2'd2, 0, 0); chk("R7 cur loaded", reg_rdata, 32'd4);
        // R10 current-count write ignored, reads have no effect
        wr(2'd2, 32'h0000_ABCD); chk("R10 cur write ignored", reg_rdata, 32'd4);
        step(0, 2'd2, 0, 0); chk("R10 read no effect", reg_rdata, 32'd4);
        run(10, 0, cnt, first, last);
        chk("R7 restart expiry", first, 32'd4);

        // R8 masked expiry then late unmask
        wr(2'd0, 32'h0001_0020);
        wr(2'd1, 32'd3);
        run(10, 0, cnt, first, last);
        chk("R8 masked no request", cnt, 32'd0);
        wr(2'd0, 32'h0000_0020);
        run(10, 0, cnt, first, last);
        chk("R8 unmask no revive", cnt, 32'd0);

        // Mixed traffic against the model
        lfsr = 32'hACE1_2468;
        for (int i = 0; i < 3000; i++) begin
            lfsr = {lfsr[30:0], lfsr[31] ^ lfsr[21] ^ lfsr[1] ^ lfsr[0]};
            if (lfsr[7:0] < 8'd6)
                step(1, 2'd1, {28'd0, lfsr[11:8]}, lfsr[12]);
            else if (lfsr[7:0] < 8'd9)
                step(1, 2'd0, {14'd0, lfsr[13], lfsr[14] & lfsr[15], 5'd0, lfsr[18:8]}, lfsr[12]);
            else if (lfsr[7:0] < 8'd11)
                step(1, 2'd3, {28'd0, lfsr[19:16]}, lfsr[12]);
            else
                step(0, lfsr[21:20], 32'd0, lfsr[12] | lfsr[13]);
        end

        done = 1;
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule